// File: doc/BRIEF.md
# Framed Serial Sample Transmitter

This block is the master-side serial output port of a sampling converter that delivers one 16-bit result every 64 master-clock cycles. It derives its own serial bit clock at half the master rate, frames every result in a 32-bit-clock slot, and sends the word most significant bit first. The second half of every slot carries forced zeros. A frame marker output announces the slot in one of two styles, and a polarity select decides which edge of the serial clock the data changes on.

A frame-sync input can realign the slot to an external event, so several converters on one master clock can keep the same frame phase. The serial data line can be tri-stated under control of an enable input. Two transmitters can then share one wire, each driving it in alternate frames. A new result is handed over as a parallel word with a one-cycle strobe, and it is only moved into the shifter at a frame boundary.

Top module: `sertx_framed`

## Requirements
- R1: The serial clock toggles on every rising master-clock edge. Phase p (0..63) is counted from the frame start. In phase p the serial clock equals bit 0 of p XOR `clk_inv`. A frame is 64 master cycles (32 serial clocks) long and repeats on its own without any frame-sync.
- R2: During serial clock k (phases 2k and 2k+1) for k = 0..15, the data line carries bit 15-k of the frame's word, MSB first. The value changes at the start of each even phase.
- R3: During serial clocks 16..31 (phases 32..63) the data line is driven to 0.
- R4: With `fs_pulse` = 0, the frame output is low in phases 0..31 and high in phases 32..63.
- R5: With `fs_pulse` = 1, the frame output is high only in phases 0 and 1 (the first serial clock) and low otherwise.
- R6: `clk_inv` = 1 inverts the serial clock. Data then changes on the rising serial-clock edge instead of the falling one, so the receiver samples on the other edge.
- R7: `fsync_in` is sampled on the falling master-clock edge. A low-to-high change seen there makes the following rising edge start a new frame at phase 0. A frame-sync held high restarts the frame only once.
- R8: `word_stb` captures `word_in` into a pending register. The pending word enters the shifter at each frame start. A word strobed mid-frame, or on the very edge that starts a frame, is first sent in the frame after that start. If no new word arrives, the previous word is sent again.
- R9: With `tri_sel` = 1, the data line is driven while `dout_en` = 1 and left undriven (high impedance, so a pull-up on the line shows 1) while `dout_en` = 0. The switch takes effect in the same cycle. With `tri_sel` = 0, the line is always driven and `dout_en` has no effect.
- R10: Synchronous active-high reset holds phase 0 and clears the pending and shift registers. During reset the serial clock equals `clk_inv`, the data line is 0, and the frame output is 0 (level style) or 1 (pulse style).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| fsync_in | input | 1 | Frame realignment request, sampled on the falling clock edge |
| word_in | input | 16 | Parallel result word |
| word_stb | input | 1 | One-cycle strobe that captures `word_in` |
| clk_inv | input | 1 | Serial clock polarity select |
| fs_pulse | input | 1 | Frame output style: 0 level, 1 pulse |
| tri_sel | input | 1 | Enables tri-state control of the data line |
| dout_en | input | 1 | Data line drive enable when `tri_sel` is 1 |
| sclk_out | output | 1 | Serial bit clock |
| fso | output | 1 | Frame marker output |
| sdo | output | 1 | Tri-statable serial data |

## Verification
The clock, frame and data outputs are decoded without registers from the phase counter and the shifter. Each one therefore reflects the state set at the last rising edge, and the bench samples it one step after the falling edge. A frame-sync raised just after a rising edge is caught at the next falling edge and gives phase 0 after the rising edge after that. The bench starts counting phases from that point. A strobed word appears no earlier than the next frame start, and the bench checks both the frame in progress and the frame that follows. A change on `dout_en` reaches the line at once, so it is set and checked within the same half cycle.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int unsigned WORD_W     = 16;
    localparam int unsigned FRAME_CLKS = 64;

    typedef enum logic {
        FS_LEVEL = 1'b0,
        FS_PULSE = 1'b1
    } fs_style_e;

    typedef struct packed {
        logic sclk;
        logic fso;
        logic dbit;
        logic drive;
    } pin_bundle_t;

    function automatic logic serial_clock(input logic phase_lsb, input logic invert);
        return phase_lsb ^ invert;
    endfunction

endpackage

// File: rtl/sertx_phase.sv
module sertx_phase #(
    parameter int unsigned FRAME_CLKS = sertx_pkg::FRAME_CLKS,
    localparam int unsigned PW = $clog2(FRAME_CLKS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fsync_in,
    output logic [PW-1:0] phase,
    output logic          restart,
    output logic          frame_load
);
    localparam logic [PW-1:0] LAST_PHASE = PW'(FRAME_CLKS - 1);

    logic fs_fall_q;
    logic fs_prev_q;

    always_ff @(negedge clk) begin
        if (rst) fs_fall_q <= 1'b0;
        else     fs_fall_q <= fsync_in;
    end

    always_ff @(posedge clk) begin
        if (rst) fs_prev_q <= 1'b0;
        else     fs_prev_q <= fs_fall_q;
    end

    assign restart    = fs_fall_q & ~fs_prev_q;
    assign frame_load = restart | (phase == LAST_PHASE);

    always_ff @(posedge clk) begin
        if (rst)          phase <= '0;
        else if (restart) phase <= '0;
        else              phase <= phase + 1'b1;
    end

endmodule

// File: rtl/sertx_word.sv
module sertx_word #(
    parameter int unsigned WORD_W = sertx_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_stb,
    input  logic              frame_load,
    input  logic              shift_en,
    output logic              msb
);
    logic [WORD_W-1:0] pending_q;
    logic [WORD_W-1:0] shift_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= '0;
            shift_q   <= '0;
        end else begin
            if (word_stb)
                pending_q <= word_in;
            if (frame_load)
                shift_q <= pending_q;
            else if (shift_en)
                shift_q <= {shift_q[WORD_W-2:0], 1'b0};
        end
    end

    assign msb = shift_q[WORD_W-1];

endmodule

// File: rtl/sertx_pins.sv
module sertx_pins #(
    parameter int unsigned WORD_W     = sertx_pkg::WORD_W,
    parameter int unsigned FRAME_CLKS = sertx_pkg::FRAME_CLKS,
    localparam int unsigned PW = $clog2(FRAME_CLKS),
    localparam int unsigned SW = PW - 1
) (
    input  logic                   [PW-1:0] phase,
    input  logic                            clk_inv,
    input  sertx_pkg::fs_style_e            style,
    input  logic                            msb,
    input  logic                            tri_sel,
    input  logic                            dout_en,
    output sertx_pkg::pin_bundle_t          pins
);
    import sertx_pkg::*;

    localparam logic [SW-1:0] TAIL_START = SW'(WORD_W);

    logic [SW-1:0] sidx;
    logic          in_tail;

    assign sidx    = phase[PW-1:1];
    assign in_tail = (sidx >= TAIL_START);

    always_comb begin
        pins.sclk  = serial_clock(phase[0], clk_inv);
        pins.fso   = (style == FS_PULSE) ? (sidx == '0) : in_tail;
        pins.dbit  = in_tail ? 1'b0 : msb;
        pins.drive = ~tri_sel | dout_en;
    end

endmodule

// File: rtl/sertx_framed.sv
module sertx_framed #(
    parameter int unsigned WORD_W     = sertx_pkg::WORD_W,
    parameter int unsigned FRAME_CLKS = sertx_pkg::FRAME_CLKS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fsync_in,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_stb,
    input  logic              clk_inv,
    input  logic              fs_pulse,
    input  logic              tri_sel,
    input  logic              dout_en,
    output logic              sclk_out,
    output logic              fso,
    output logic              sdo
);
    import sertx_pkg::*;

    localparam int unsigned PW = $clog2(FRAME_CLKS);
    localparam int unsigned SW = PW - 1;
    localparam logic [SW-1:0] TAIL_START = SW'(WORD_W);

    logic [PW-1:0] phase;
    logic          restart;
    logic          frame_load;
    logic          shift_en;
    logic          msb;
    logic          sdo_drive;
    pin_bundle_t   pins;

    sertx_phase #(.FRAME_CLKS(FRAME_CLKS)) u_phase (
        .clk        (clk),
        .rst        (rst),
        .fsync_in   (fsync_in),
        .phase      (phase),
        .restart    (restart),
        .frame_load (frame_load)
    );

    assign shift_en = phase[0] & (phase[PW-1:1] < TAIL_START);

    sertx_word #(.WORD_W(WORD_W)) u_word (
        .clk        (clk),
        .rst        (rst),
        .word_in    (word_in),
        .word_stb   (word_stb),
        .frame_load (frame_load),
        .shift_en   (shift_en),
        .msb        (msb)
    );

    sertx_pins #(.WORD_W(WORD_W), .FRAME_CLKS(FRAME_CLKS)) u_pins (
        .phase   (phase),
        .clk_inv (clk_inv),
        .style   (fs_style_e'(fs_pulse)),
        .msb     (msb),
        .tri_sel (tri_sel),
        .dout_en (dout_en),
        .pins    (pins)
    );

    assign sclk_out  = pins.sclk;
    assign fso       = pins.fso;
    assign sdo_drive = pins.drive;
    assign sdo       = sdo_drive ? pins.dbit : 1'bz;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
    parameter int unsigned WORD_W     = 16,
    parameter int unsigned FRAME_CLKS = 64,
    localparam int unsigned PW = $clog2(FRAME_CLKS)
) (
    input logic          clk,
    input logic          rst,
    input logic [PW-1:0] phase,
    input logic          restart,
    input logic          clk_inv,
    input logic          fs_pulse,
    input logic          tri_sel,
    input logic          dout_en,
    input logic          sdo_drive,
    input logic          sclk_out,
    input logic          fso,
    input logic          sdo
);
    localparam logic [PW-1:0] TAIL_PHASE = PW'(2 * WORD_W);

    // R1: serial clock flips each cycle unless a restart or reset intervened
    a_r1_sclk_toggle: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(restart) && $stable(clk_inv)) |-> (sclk_out != $past(sclk_out)));

    // R7: the cycle after a restart is phase 0, so the clock sits at its idle level
    a_r7_restart_idle: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(restart)) |-> (sclk_out == clk_inv));

    // R3: tail half carries zeros whenever the line is driven
    a_r3_tail_zero: assert property (@(posedge clk) disable iff (rst)
        (sdo_drive && phase >= TAIL_PHASE) |-> (sdo == 1'b0));

    // R4: level-style marker rises exactly where the tail begins
    a_r4_level_rise: assert property (@(posedge clk) disable iff (rst)
        (!fs_pulse && $stable(fs_pulse) && $rose(fso)) |-> (phase == TAIL_PHASE));

    // R5: pulse-style marker rises only at frame start
    a_r5_pulse_rise: assert property (@(posedge clk) disable iff (rst)
        (fs_pulse && $stable(fs_pulse) && $rose(fso)) |-> (phase == '0));

    // R9: released line is not driven
    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        (tri_sel && !dout_en) |-> !sdo_drive);

endmodule

bind sertx_framed sertx_chk #(.WORD_W(WORD_W), .FRAME_CLKS(FRAME_CLKS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .restart   (restart),
    .clk_inv   (clk_inv),
    .fs_pulse  (fs_pulse),
    .tri_sel   (tri_sel),
    .dout_en   (dout_en),
    .sdo_drive (sdo_drive),
    .sclk_out  (sclk_out),
    .fso       (fso),
    .sdo       (sdo)
);

// File: tb/test_sertx_framed.sv
module test_sertx_framed;

    localparam int CLK_PERIOD = 10;

    // vector: {word, clk_inv, fs_pulse, tri_sel}
    localparam logic [18:0] VEC [6] = '{
        {16'hA5C3, 1'b0, 1'b0, 1'b0},
        {16'h8001, 1'b1, 1'b0, 1'b0},
        {16'h7FFE, 1'b0, 1'b1, 1'b0},
        {16'hFFFF, 1'b1, 1'b1, 1'b0},
        {16'h0000, 1'b0, 1'b0, 1'b1},
        {16'h3C96, 1'b1, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fsync_in = 1'b0;
    logic [15:0] word_in = '0;
    logic        word_stb = 1'b0;
    logic        clk_inv = 1'b0;
    logic        fs_pulse = 1'b0;
    logic        tri_sel = 1'b0;
    logic        dout_en = 1'b0;
    logic        sclk_out;
    logic        fso;
    wire         sdo_w;
    pullup (sdo_w);

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sertx_framed i_sertx_framed (
        .clk      (clk),
        .rst      (rst),
        .fsync_in (fsync_in),
        .word_in  (word_in),
        .word_stb (word_stb),
        .clk_inv  (clk_inv),
        .fs_pulse (fs_pulse),
        .tri_sel  (tri_sel),
        .dout_en  (dout_en),
        .sclk_out (sclk_out),
        .fso      (fso),
        .sdo      (sdo_w)
    );

    task automatic check1(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic strobe(input logic [15:0] w);
        @(posedge clk); #1;
        word_in  = w;
        word_stb = 1'b1;
        @(posedge clk); #1;
        word_stb = 1'b0;
    endtask

    // R7: raise frame-sync after a rising edge; phase 0 follows the next rising edge
    task automatic restart_frame(input bit hold);
        @(posedge clk); #1;
        fsync_in = 1'b1;
        @(posedge clk); #1;
        if (!hold) fsync_in = 1'b0;
    endtask

    task automatic check_frame(input logic [15:0] w, input int stb_p,
                               input logic [15:0] stb_w, input string dtag);
        for (int p = 0; p < 64; p++) begin
            logic exp_d;
            logic exp_line;
            string tag;
            @(negedge clk);
            dout_en = ((p / 4) % 2) == 1;
            #1;
            check1(clk_inv ? "R6" : "R1", "sclk", sclk_out, logic'(p % 2) ^ clk_inv);
            check1(fs_pulse ? "R5" : "R4", "fso", fso, fs_pulse ? (p < 2) : (p >= 32));
            exp_d    = (p < 32) ? w[15 - p / 2] : 1'b0;
            exp_line = (!tri_sel || dout_en) ? exp_d : 1'b1;
            if (tri_sel)       tag = "R9";
            else if (p >= 32)  tag = "R3";
            else if (dtag != "") tag = dtag;
            else               tag = "R2";
            check1(tag, "sdo", sdo_w, exp_line);
            if (p == stb_p) begin
                word_in  = stb_w;
                word_stb = 1'b1;
                @(posedge clk); #1;
                word_stb = 1'b0;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R10: reset state, level style, normal polarity
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check1("R10", "sclk", sclk_out, 1'b0);
        check1("R10", "fso", fso, 1'b0);
        check1("R10", "sdo", sdo_w, 1'b0);
        clk_inv  = 1'b1;
        fs_pulse = 1'b1;
        #1;
        check1("R10", "sclk inv", sclk_out, 1'b1);
        check1("R10", "fso pulse", fso, 1'b1);
        check1("R10", "sdo", sdo_w, 1'b0);
        @(posedge clk); #1;
        rst = 1'b0;
        clk_inv  = 1'b0;
        fs_pulse = 1'b0;

        // table walk: R1..R6, R9
        for (int i = 0; i < 6; i++) begin
            logic [18:0] v;
            v = VEC[i];
            clk_inv  = v[2];
            fs_pulse = v[1];
            tri_sel  = v[0];
            strobe(v[18:3]);
            restart_frame(1'b0);
            check_frame(v[18:3], -1, 16'h0000, "");
        end
        tri_sel  = 1'b0;
        clk_inv  = 1'b0;
        fs_pulse = 1'b0;

        // R8: mid-frame word waits; word on boundary edge waits one more frame
        strobe(16'hC0DE);
        restart_frame(1'b0);
        check_frame(16'hC0DE, 10, 16'h1234, "R8");
        check_frame(16'h1234, 63, 16'hF00F, "R8");
        check_frame(16'h1234, -1, 16'h0000, "R8");
        check_frame(16'hF00F, -1, 16'h0000, "R8");

        // R7: held frame-sync restarts once; R1 free-running wrap afterwards
        strobe(16'h5AA5);
        restart_frame(1'b1);
        check_frame(16'h5AA5, -1, 16'h0000, "R7");
        check_frame(16'h5AA5, -1, 16'h0000, "R7");
        fsync_in = 1'b0;

        // R7: restart in the middle of a running frame
        clk_inv = 1'b1;
        repeat (21) @(posedge clk);
        strobe(16'h0F0F);
        restart_frame(1'b0);
        check_frame(16'h0F0F, -1, 16'h0000, "R7");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule